// File: doc/BRIEF.md
# Prioritised Burst Framer for Five Buffered Streams

This block gathers words from five independent capture streams and sends them out on one 32-bit output stream. Sources 0 and 1 are the fast serial-link streams. Sources 2, 3 and 4 are the slower sampled-data streams. Each source writes into its own 16-word single-clock buffer.

A buffer is eligible for service once it holds more words than a shared run-time threshold. While the framer is idle it looks at every eligible buffer and grants the lowest-numbered one. It then sends a tagged header word, followed by one complete burst from that buffer. A burst is never interrupted by another source.

The output uses a valid/ready handshake. Everything runs on one clock with a synchronous, active-high reset.

Top module: `prio_frame_mux`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `overflow` is all zeros.
- R2: Each source has its own buffer holding up to DEPTH (16) words. The payload words of a source leave in the order they were written.
- R3: A write to a full buffer is dropped and sets that source's `overflow` bit. The bit stays set until reset. Fullness is judged on the occupancy before the edge, even if the same buffer is popped on that edge.
- R4: A source is eligible only when its occupancy before the edge is strictly greater than `thresh`. The threshold must be at least BURST-1, so an eligible source always holds a whole burst.
- R5: Among eligible sources, the lowest index wins. Indices 0 and 1 (fast streams) outrank indices 2 to 4 (slow streams).
- R6: A grant first presents a header word. Bits 31:24 are 0xA5, bits 23:19 are zero, bits 18:16 carry the source index, and bits 15:0 carry BURST.
- R7: After its header, a grant sends exactly BURST payload words from the granted source. No other source's words are interleaved.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value. A buffer word is consumed only on a cycle with both valid and ready high.
- R9: After the last payload word is accepted, `out_valid` is 0 for one cycle while arbitration restarts from index 0. `thresh` is only looked at in that idle state, so changing it during a burst does not affect the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-source write strobe |
| in_data | input | 160 | Per-source write data; source i uses bits 32*i+31 down to 32*i |
| thresh | input | 5 | Shared eligibility threshold |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Header or payload word |
| overflow | output | 5 | Sticky per-source dropped-write flags |

## Verification
Two things can land on the same clock edge:
- a producer writing into a buffer that is already full, and
- the framer popping that same buffer.

The bench provokes this by filling one source to 16 words while its burst is stalled, and then by random writes during random-ready drains. Its model judges fullness on the occupancy before the edge, so the write must still be dropped and the overflow bit must rise.

A second coincidence is a write that arrives on the very edge where the idle framer decides. The model arbitrates on the pre-edge occupancy, so that write must not affect the grant until the next decision.

// File: rtl/prio_frame_mux.sv
module prio_frame_mux #(
  parameter int NSRC  = 5,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  parameter int THW   = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int BCW  = $clog2(BURST) + 1,
  localparam int IDW  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     in_valid,
  input  logic [NSRC*DW-1:0]  in_data,
  input  logic [THW-1:0]      thresh,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic [NSRC-1:0]     overflow
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} st_t;

  st_t            state;
  logic [IDW-1:0] sel;
  logic [BCW-1:0] beat;

  logic [DW-1:0]  mem [NSRC][DEPTH];
  logic [AW:0]    wp  [NSRC];
  logic [AW:0]    rp  [NSRC];
  logic [AW:0]    cnt [NSRC];
  logic [NSRC-1:0] full, elig, pop;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign cnt[g]  = wp[g] - rp[g];
    assign full[g] = cnt[g] == (AW+1)'(DEPTH);
    assign elig[g] = 32'(cnt[g]) > 32'(thresh);
    assign pop[g]  = (state == S_PAY) && (32'(sel) == g) && out_ready;

    always_ff @(posedge clk) begin
      if (in_valid[g] && !full[g])
        mem[g][wp[g][AW-1:0]] <= in_data[g*DW +: DW];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp[g]       <= '0;
        rp[g]       <= '0;
        overflow[g] <= 1'b0;
      end else begin
        if (in_valid[g]) begin
          if (full[g]) overflow[g] <= 1'b1;
          else         wp[g]       <= wp[g] + 1'b1;
        end
        if (pop[g]) rp[g] <= rp[g] + 1'b1;
      end
    end
  end

  logic [IDW-1:0] win;
  always_comb begin
    win = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (elig[i]) win = IDW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      sel   <= '0;
      beat  <= '0;
    end else begin
      case (state)
        S_IDLE: if (|elig) begin
          sel   <= win;
          state <= S_HDR;
        end
        S_HDR: if (out_ready) begin
          beat  <= '0;
          state <= S_PAY;
        end
        S_PAY: if (out_ready) begin
          beat <= beat + 1'b1;
          if (beat == BCW'(BURST-1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [DW-1:0] hdr, head;
  assign hdr       = {8'hA5, 5'b0, sel, 16'(BURST)};
  assign head      = mem[sel][rp[sel][AW-1:0]];
  assign out_valid = state != S_IDLE;
  assign out_data  = (state == S_HDR) ? hdr : head;

endmodule

module prio_frame_mux_chk #(
  parameter int NSRC  = 5,
  parameter int DW    = 32,
  parameter int BURST = 4,
  localparam int BCW  = $clog2(BURST) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_data,
  input logic [NSRC-1:0] overflow,
  input logic [1:0]      st,
  input logic [BCW-1:0]  beat
);

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && overflow == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ((overflow & $past(overflow)) == $past(overflow)));

  p_hdr_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_data[31:24] == 8'hA5 && out_data[15:0] == 16'(BURST)));

  p_gap_after_burst_r9: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2 && out_ready && beat == BCW'(BURST-1)) |=> !out_valid);

endmodule

bind prio_frame_mux prio_frame_mux_chk #(.NSRC(NSRC), .DW(DW), .BURST(BURST)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .overflow(overflow), .st(state), .beat(beat)
);

// File: tb/prio_frame_mux_tb.sv
module prio_frame_mux_tb;
  localparam int NSRC = 5, DW = 32, DEPTH = 16, BURST = 4;

  logic               clk = 0;
  logic               rst = 1;
  logic [NSRC-1:0]    in_valid = '0;
  logic [NSRC*DW-1:0] in_data = '0;
  logic [4:0]         thresh = 5'd3;
  logic               out_valid, out_ready = 0;
  logic [DW-1:0]      out_data;
  logic [NSRC-1:0]    overflow;

  prio_frame_mux u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .thresh(thresh),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .overflow(overflow)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] mq [NSRC][DEPTH];
  int mcnt [NSRC], mwr [NSRC], mrd [NSRC];
  logic [NSRC-1:0] movf;
  int mstate, msel, mbeat;
  logic pv, pr;
  logic [DW-1:0] pd;

  function automatic logic [DW-1:0] hdr_of(int id);
    return {8'hA5, 5'b0, 3'(id), 16'(BURST)};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [NSRC-1:0] iv, logic rdy, logic [4:0] th);
    int c0 [NSRC];
    int nstate;
    int w;
    @(negedge clk);
    in_valid  = iv;
    out_ready = rdy;
    thresh    = th;
    for (int i = 0; i < NSRC; i++) in_data[i*DW +: DW] = $urandom;
    #1;
    for (int i = 0; i < NSRC; i++) c0[i] = mcnt[i];
    chk(overflow == movf, "R3", DW'(overflow), DW'(movf));
    if (pv && !pr) chk(out_data == pd, "R8", out_data, pd);
    nstate = mstate;
    case (mstate)
      0: begin
        chk(out_valid == 1'b0, "R9", DW'(out_valid), 0);
        w = -1;
        for (int i = NSRC-1; i >= 0; i--) if (c0[i] > int'(th)) w = i;
        if (w >= 0) begin msel = w; nstate = 1; end
      end
      1: begin
        chk(out_valid == 1'b1, "R4", DW'(out_valid), 1);
        chk(out_data == hdr_of(msel), "R5/R6 header", out_data, hdr_of(msel));
        if (rdy) begin nstate = 2; mbeat = 0; end
      end
      default: begin
        chk(out_valid == 1'b1, "R7", DW'(out_valid), 1);
        chk(out_data == mq[msel][mrd[msel]], "R2/R7 payload", out_data, mq[msel][mrd[msel]]);
        if (rdy) begin
          mrd[msel] = (mrd[msel] + 1) % DEPTH;
          mcnt[msel]--;
          mbeat++;
          if (mbeat == BURST) nstate = 0;
        end
      end
    endcase
    mstate = nstate;
    for (int i = 0; i < NSRC; i++)
      if (iv[i]) begin
        if (c0[i] == DEPTH) movf[i] = 1'b1;
        else begin
          mq[i][mwr[i]] = in_data[i*DW +: DW];
          mwr[i] = (mwr[i] + 1) % DEPTH;
          mcnt[i]++;
        end
      end
    pv = out_valid; pr = rdy; pd = out_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] th;
    void'($urandom(32'd1234));
    for (int i = 0; i < NSRC; i++) begin mcnt[i] = 0; mwr[i] = 0; mrd[i] = 0; end
    movf = '0; mstate = 0; msel = 0; mbeat = 0; pv = 0; pr = 0; pd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", DW'(out_valid), 0);
    chk(overflow == '0, "R1", DW'(overflow), 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", DW'(out_valid), 0);
    chk(overflow == '0, "R1", DW'(overflow), 0);

    // R5: all sources eligible at once, grants must come in index order
    for (int k = 0; k < 5; k++) step('1, 1'b0, 5'd3);
    for (int k = 0; k < 40; k++) step('0, 1'b1, 5'd3);

    // R3: fill source 2 while its burst is stalled; then pop on a full edge
    for (int k = 0; k < 20; k++) step(5'b00100, 1'b0, 5'd15);
    step(5'b00100, 1'b0, 5'd15);
    for (int k = 0; k < 4; k++) step(5'b00100, 1'b1, 5'd15);
    for (int k = 0; k < 60; k++) step('0, 1'b1, 5'd3);

    // R4/R9: threshold above occupancy blocks grants
    for (int k = 0; k < 3; k++) step(5'b00001, 1'b1, 5'd10);
    for (int k = 0; k < 10; k++) step('0, 1'b1, 5'd10);

    // random phase: threshold changes mid-burst, random back-pressure
    th = 5'd3;
    for (int k = 0; k < 4000; k++) begin
      logic [NSRC-1:0] iv;
      if (k % 37 == 0) th = 5'(3 + $urandom_range(0, 12));
      for (int i = 0; i < NSRC; i++) iv[i] = ($urandom_range(0, 99) < 30);
      step(iv, ($urandom_range(0, 99) < 60), th);
    end
    for (int k = 0; k < 300; k++) step('0, 1'b1, 5'd3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule